// File: doc/BRIEF.md
# Hart Debug Halt Controller

This block holds the debug control and status register of one processor hart and decides, every cycle, whether the hart must stop and enter Debug Mode and why. The pipeline reports four kinds of entry event as single-cycle pulses:
- an ebreak retiring;
- a trigger match;
- a debugger halt request;
- the completion of a single-stepped instruction.

With these events the pipeline supplies the current privilege level and the address at which execution should later resume. When any accepted event arrives outside Debug Mode, the block raises a one-cycle entry request. From the next cycle it reports Debug Mode, and it records the cause, the privilege level and the resume address.

While halted, the block drives stop enables for the performance counters and the timers, and it produces an interrupt mask for stepping. Software in Debug Mode reads and writes the control register at CSR address 0x7b0 and the saved resume address at 0x7b1. On a resume pulse the block leaves Debug Mode, and the pipeline takes the privilege and the address to continue from the saved fields.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: After reset the block is outside Debug Mode, the control register reads 0x40000003 (version 4 in bits 31:28, privilege 3 in bits 1:0, all else zero) and the saved address reads 0.
- R2: Several events in one cycle are resolved with step completion highest, then halt request, then ebreak, then trigger lowest. The recorded cause code is 4 for step, 3 for halt request, 1 for ebreak and 2 for trigger, and it is visible in bits 8:6.
- R3: An ebreak causes entry only if its privilege's enable is set: bit 15 for privilege 3, bit 13 for privilege 1, bit 12 for privilege 0. At privilege 2 an ebreak never causes entry.
- R4: A step-completion pulse causes entry only while the step bit (bit 2) is set.
- R5: In a cycle with an accepted event outside Debug Mode, `enter_o` is high in that same cycle. From the next cycle `debug_mode_o` is high, bits 1:0 hold the privilege of the entry cycle, and the saved address holds `resume_pc_i` with bit 0 cleared.
- R6: While in Debug Mode, entry events have no effect: `enter_o` stays low and the cause, privilege and saved address keep their values.
- R7: A resume pulse in Debug Mode clears `debug_mode_o` in the next cycle. `saved_priv_o` and `dpc_o` then present bits 1:0 and the saved address. A resume pulse outside Debug Mode has no effect.
- R8: `stop_count_o` is high when bit 10 is set and the block is either in Debug Mode or entering it because of an ebreak in the current cycle. `stop_time_o` is high when bit 9 is set and the block is in Debug Mode.
- R9: `irq_mask_o` is high outside Debug Mode when the step bit is set and bit 11 (interrupts allowed while stepping) is clear.
- R10: The writable bits of the control register are 15, 13, 12, 11, 10, 9, 2 and 1:0. Bits 31:28 always read 4, the cause is unchanged by writes, and all other bits read 0. The saved address is writable at 0x7b1 with bit 0 reading 0. Other addresses read 0 and writes to them have no effect.
- R11: When a register write and an entry fall in the same cycle, the entry's cause, privilege and address take precedence, and the other written fields take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ebreak_i | input | 1 | Pulse: an ebreak retired |
| trigger_i | input | 1 | Pulse: a trigger matched |
| haltreq_i | input | 1 | Pulse: debugger requests a halt |
| step_done_i | input | 1 | Pulse: one instruction completed (or trapped) while stepping |
| cur_priv_i | input | 2 | Current privilege level |
| resume_pc_i | input | XLEN | Address to resume at if entry happens this cycle |
| resume_i | input | 1 | Pulse: leave Debug Mode |
| csr_we_i | input | 1 | CSR write strobe |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | XLEN | CSR write data |
| csr_rdata_o | output | XLEN | CSR read data for `csr_addr_i` |
| debug_mode_o | output | 1 | Hart is in Debug Mode |
| enter_o | output | 1 | Entry request this cycle |
| cause_o | output | 3 | Recorded entry cause |
| saved_priv_o | output | 2 | Privilege field, restored on resume |
| dpc_o | output | XLEN | Saved resume address |
| stop_count_o | output | 1 | Hold cycle and instret counters |
| stop_time_o | output | 1 | Hold timers |
| irq_mask_o | output | 1 | Mask interrupts while stepping |

## Verification
On every cycle, assertions check the following: at most one entry reason is granted, an entry always lands in Debug Mode with the entry cycle's privilege, the cause does not move while halted, a resume always leaves Debug Mode, and the timer stop and interrupt mask never contradict the mode. Only the bench's scenarios show the arithmetic content of the behaviour. The sweep covers all event combinations, privilege levels, ebreak enable patterns and step settings. It shows the exact cause code chosen, the per-privilege ebreak gating and the read-back masking of the register. It also shows the precedence of entry over a simultaneous register write.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;

  typedef enum logic [2:0] {
    CAUSE_NONE    = 3'd0,
    CAUSE_EBREAK  = 3'd1,
    CAUSE_TRIGGER = 3'd2,
    CAUSE_HALTREQ = 3'd3,
    CAUSE_STEP    = 3'd4
  } dbg_cause_e;

  // Control register bit positions (decoded by debugger software).
  localparam int unsigned BIT_EBM     = 15;
  localparam int unsigned BIT_EBS     = 13;
  localparam int unsigned BIT_EBU     = 12;
  localparam int unsigned BIT_STEPIE  = 11;
  localparam int unsigned BIT_STOPCNT = 10;
  localparam int unsigned BIT_STOPTIM = 9;
  localparam int unsigned BIT_CAUSE   = 6;
  localparam int unsigned BIT_STEP    = 2;
  localparam int unsigned BIT_VER     = 28;

  localparam logic [3:0]  DBG_VERSION = 4'd4;
  localparam logic [11:0] ADDR_CTRL   = 12'h7b0;
  localparam logic [11:0] ADDR_RPC    = 12'h7b1;

  // Number of entry reasons, listed from highest to lowest priority.
  localparam int unsigned N_REASON = 4;

  typedef struct packed {
    logic       eb_m;
    logic       eb_s;
    logic       eb_u;
    logic       stepie;
    logic       stopcnt;
    logic       stoptim;
    logic       step;
    logic [1:0] prv;
  } dbg_ctl_t;

  localparam dbg_ctl_t CTL_RESET = '{eb_m: 1'b0, eb_s: 1'b0, eb_u: 1'b0,
                                     stepie: 1'b0, stopcnt: 1'b0,
                                     stoptim: 1'b0, step: 1'b0, prv: 2'b11};

endpackage

// File: rtl/dbg_cause_arb.sv
module dbg_cause_arb
  import dbg_halt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active_i,
  input  logic       step_done_i,
  input  logic       step_en_i,
  input  logic       haltreq_i,
  input  logic       ebreak_i,
  input  logic       trigger_i,
  input  logic [1:0] priv_i,
  input  logic       eb_m_i,
  input  logic       eb_s_i,
  input  logic       eb_u_i,
  output logic       take_o,
  output dbg_cause_e cause_o,
  output logic       ebreak_take_o
);

  logic                eb_allowed;
  logic [N_REASON-1:0] req;
  logic [N_REASON-1:0] grant;
  logic                found;

  // Per-privilege ebreak enable selection.
  always_comb begin
    case (priv_i)
      2'b11:   eb_allowed = eb_m_i;
      2'b01:   eb_allowed = eb_s_i;
      2'b00:   eb_allowed = eb_u_i;
      default: eb_allowed = 1'b0;
    endcase
  end

  // Requests in priority order: index 0 wins.
  always_comb begin
    req[0] = active_i & step_done_i & step_en_i;
    req[1] = active_i & haltreq_i;
    req[2] = active_i & ebreak_i & eb_allowed;
    req[3] = active_i & trigger_i;
  end

  always_comb begin
    grant = '0;
    found = 1'b0;
    for (int i = 0; i < N_REASON; i++) begin
      if (req[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    unique case (1'b1)
      grant[0]: cause_o = CAUSE_STEP;
      grant[1]: cause_o = CAUSE_HALTREQ;
      grant[2]: cause_o = CAUSE_EBREAK;
      grant[3]: cause_o = CAUSE_TRIGGER;
      default:  cause_o = CAUSE_NONE;
    endcase
  end

  assign take_o        = |grant;
  assign ebreak_take_o = grant[2];

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R3
  eb_prv2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_i == 2'b10) |-> !ebreak_take_o);

endmodule

// File: rtl/dbg_mode_ctl.sv
module dbg_mode_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic take_i,
  input  logic resume_i,
  output logic dm_o
);

  logic dm_q;
  logic dm_d;
  logic dm_en;

  always_comb begin
    dm_d  = dm_q;
    dm_en = 1'b0;
    if (!dm_q && take_i) begin
      dm_d  = 1'b1;
      dm_en = 1'b1;
    end else if (dm_q && resume_i) begin
      dm_d  = 1'b0;
      dm_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dm_q <= 1'b0;
    end else if (dm_en) begin
      dm_q <= dm_d;
    end
  end

  assign dm_o = dm_q;

  // R5
  enter_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> dm_q);

  // R7
  resume_leaves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dm_q && resume_i) |=> !dm_q);

endmodule

// File: rtl/dbg_csr_regs.sv
module dbg_csr_regs
  import dbg_halt_pkg::*;
#(
  parameter int unsigned XLEN        = 32,
  parameter bit          STEPIE_IMPL = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dm_i,
  input  logic            take_i,
  input  dbg_cause_e      cause_i,
  input  logic [1:0]      priv_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic            we_i,
  input  logic [11:0]     addr_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] rdata_o,
  output dbg_ctl_t        ctl_o,
  output dbg_cause_e      cause_o,
  output logic [XLEN-1:0] rpc_o
);

  localparam logic [XLEN-1:0] ALIGN_MASK = ~XLEN'(1);

  dbg_ctl_t        ctl_q, ctl_d;
  dbg_cause_e      cause_q, cause_d;
  logic [XLEN-1:0] rpc_q, rpc_d;
  logic            ctl_en, cause_en, rpc_en;
  logic            wr_ctl, wr_rpc;
  logic            stepie_wr;
  logic [31:0]     ctl_view;

  generate
    if (STEPIE_IMPL) begin : g_stepie
      assign stepie_wr = wdata_i[BIT_STEPIE];
    end else begin : g_stepie_tied
      assign stepie_wr = 1'b0;
    end
  endgenerate

  assign wr_ctl = we_i && (addr_i == ADDR_CTRL);
  assign wr_rpc = we_i && (addr_i == ADDR_RPC);

  always_comb begin
    ctl_d   = ctl_q;
    cause_d = cause_q;
    rpc_d   = rpc_q;
    if (wr_ctl) begin
      ctl_d.eb_m    = wdata_i[BIT_EBM];
      ctl_d.eb_s    = wdata_i[BIT_EBS];
      ctl_d.eb_u    = wdata_i[BIT_EBU];
      ctl_d.stepie  = stepie_wr;
      ctl_d.stopcnt = wdata_i[BIT_STOPCNT];
      ctl_d.stoptim = wdata_i[BIT_STOPTIM];
      ctl_d.step    = wdata_i[BIT_STEP];
      ctl_d.prv     = wdata_i[1:0];
    end
    if (wr_rpc) begin
      rpc_d = wdata_i & ALIGN_MASK;
    end
    // Entry overrides a simultaneous write.
    if (take_i) begin
      cause_d   = cause_i;
      ctl_d.prv = priv_i;
      rpc_d     = pc_i & ALIGN_MASK;
    end
  end

  assign ctl_en   = wr_ctl | take_i;
  assign cause_en = take_i;
  assign rpc_en   = wr_rpc | take_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= CTL_RESET;
    end else if (ctl_en) begin
      ctl_q <= ctl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= CAUSE_NONE;
    end else if (cause_en) begin
      cause_q <= cause_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rpc_q <= '0;
    end else if (rpc_en) begin
      rpc_q <= rpc_d;
    end
  end

  always_comb begin
    ctl_view                              = '0;
    ctl_view[BIT_VER+3:BIT_VER]           = DBG_VERSION;
    ctl_view[BIT_EBM]                     = ctl_q.eb_m;
    ctl_view[BIT_EBS]                     = ctl_q.eb_s;
    ctl_view[BIT_EBU]                     = ctl_q.eb_u;
    ctl_view[BIT_STEPIE]                  = ctl_q.stepie;
    ctl_view[BIT_STOPCNT]                 = ctl_q.stopcnt;
    ctl_view[BIT_STOPTIM]                 = ctl_q.stoptim;
    ctl_view[BIT_CAUSE+2:BIT_CAUSE]       = cause_q;
    ctl_view[BIT_STEP]                    = ctl_q.step;
    ctl_view[1:0]                         = ctl_q.prv;
  end

  always_comb begin
    case (addr_i)
      ADDR_CTRL: rdata_o = XLEN'(ctl_view);
      ADDR_RPC:  rdata_o = rpc_q;
      default:   rdata_o = '0;
    endcase
  end

  assign ctl_o   = ctl_q;
  assign cause_o = cause_q;
  assign rpc_o   = rpc_q;

  // R6
  cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dm_i |=> $stable(cause_q));

  // R6
  rpc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dm_i && !wr_rpc) |=> $stable(rpc_q));

endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
  import dbg_halt_pkg::*;
#(
  parameter int unsigned XLEN        = 32,
  parameter bit          STEPIE_IMPL = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ebreak_i,
  input  logic            trigger_i,
  input  logic            haltreq_i,
  input  logic            step_done_i,
  input  logic [1:0]      cur_priv_i,
  input  logic [XLEN-1:0] resume_pc_i,
  input  logic            resume_i,
  input  logic            csr_we_i,
  input  logic [11:0]     csr_addr_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  output logic [XLEN-1:0] csr_rdata_o,
  output logic            debug_mode_o,
  output logic            enter_o,
  output logic [2:0]      cause_o,
  output logic [1:0]      saved_priv_o,
  output logic [XLEN-1:0] dpc_o,
  output logic            stop_count_o,
  output logic            stop_time_o,
  output logic            irq_mask_o
);

  logic       dm;
  logic       take;
  logic       eb_take;
  dbg_cause_e new_cause;
  dbg_cause_e cur_cause;
  dbg_ctl_t   ctl;

  dbg_cause_arb u_arb (
    .clk           (clk),
    .rst_n         (rst_n),
    .active_i      (!dm),
    .step_done_i   (step_done_i),
    .step_en_i     (ctl.step),
    .haltreq_i     (haltreq_i),
    .ebreak_i      (ebreak_i),
    .trigger_i     (trigger_i),
    .priv_i        (cur_priv_i),
    .eb_m_i        (ctl.eb_m),
    .eb_s_i        (ctl.eb_s),
    .eb_u_i        (ctl.eb_u),
    .take_o        (take),
    .cause_o       (new_cause),
    .ebreak_take_o (eb_take)
  );

  dbg_mode_ctl u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .take_i   (take),
    .resume_i (resume_i),
    .dm_o     (dm)
  );

  dbg_csr_regs #(
    .XLEN        (XLEN),
    .STEPIE_IMPL (STEPIE_IMPL)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .dm_i    (dm),
    .take_i  (take),
    .cause_i (new_cause),
    .priv_i  (cur_priv_i),
    .pc_i    (resume_pc_i),
    .we_i    (csr_we_i),
    .addr_i  (csr_addr_i),
    .wdata_i (csr_wdata_i),
    .rdata_o (csr_rdata_o),
    .ctl_o   (ctl),
    .cause_o (cur_cause),
    .rpc_o   (dpc_o)
  );

  assign debug_mode_o = dm;
  assign enter_o      = take;
  assign cause_o      = cur_cause;
  assign saved_priv_o = ctl.prv;
  assign stop_count_o = ctl.stopcnt & (dm | eb_take);
  assign stop_time_o  = ctl.stoptim & dm;
  assign irq_mask_o   = !dm & ctl.step & !ctl.stepie;

  // R5
  entry_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(debug_mode_o) |-> (saved_priv_o == $past(cur_priv_i)));

  // R8
  stop_time_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_time_o |-> debug_mode_o);

  // R9
  irq_mask_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask_o |-> !debug_mode_o);

  // R6
  no_reentry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    debug_mode_o |-> !enter_o);

endmodule

// File: tb/tb_dbg_halt_ctrl.sv
`timescale 1ns/1ps
module tb_dbg_halt_ctrl;
  localparam int unsigned XLEN = 32;
  localparam logic [11:0] A_CTRL = 12'h7b0;
  localparam logic [11:0] A_RPC  = 12'h7b1;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            ebreak_i, trigger_i, haltreq_i, step_done_i;
  logic [1:0]      cur_priv_i;
  logic [XLEN-1:0] resume_pc_i;
  logic            resume_i;
  logic            csr_we_i;
  logic [11:0]     csr_addr_i;
  logic [XLEN-1:0] csr_wdata_i;
  logic [XLEN-1:0] csr_rdata_o;
  logic            debug_mode_o, enter_o;
  logic [2:0]      cause_o;
  logic [1:0]      saved_priv_o;
  logic [XLEN-1:0] dpc_o;
  logic            stop_count_o, stop_time_o, irq_mask_o;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dbg_halt_ctrl #(.XLEN(XLEN), .STEPIE_IMPL(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .ebreak_i(ebreak_i), .trigger_i(trigger_i),
    .haltreq_i(haltreq_i), .step_done_i(step_done_i), .cur_priv_i(cur_priv_i),
    .resume_pc_i(resume_pc_i), .resume_i(resume_i), .csr_we_i(csr_we_i),
    .csr_addr_i(csr_addr_i), .csr_wdata_i(csr_wdata_i), .csr_rdata_o(csr_rdata_o),
    .debug_mode_o(debug_mode_o), .enter_o(enter_o), .cause_o(cause_o),
    .saved_priv_o(saved_priv_o), .dpc_o(dpc_o), .stop_count_o(stop_count_o),
    .stop_time_o(stop_time_o), .irq_mask_o(irq_mask_o)
  );

  task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic csr_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_we_i = 1'b1; csr_addr_i = a; csr_wdata_i = d;
    @(negedge clk);
    csr_we_i = 1'b0;
  endtask

  task automatic csr_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    csr_addr_i = a;
    #1 d = csr_rdata_o;
  endtask

  task automatic do_resume();
    @(negedge clk);
    resume_i = 1'b1;
    @(negedge clk);
    resume_i = 1'b0;
  endtask

  task automatic clear_events();
    ebreak_i = 1'b0; trigger_i = 1'b0; haltreq_i = 1'b0; step_done_i = 1'b0;
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [2:0]  exp_cause;
    logic [31:0] exp_dpc;
    int          idx;

    rst_n = 1'b0; clear_events(); cur_priv_i = 2'd3; resume_pc_i = '0;
    resume_i = 1'b0; csr_we_i = 1'b0; csr_addr_i = A_CTRL; csr_wdata_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    csr_read(A_CTRL, rd); check("R1 ctrl reset", rd, 32'h40000003);
    csr_read(A_RPC, rd);  check("R1 rpc reset", rd, 32'h0);
    check("R1 mode reset", debug_mode_o, 1'b0);

    // R10 read-only and unimplemented bits, address decode
    csr_write(A_CTRL, 32'hFFFFFFFF);
    csr_read(A_CTRL, rd); check("R10 ctrl mask", rd, 32'h4000BE07);
    csr_write(A_RPC, 32'h12345679);
    csr_read(A_RPC, rd);  check("R10 rpc bit0", rd, 32'h12345678);
    csr_write(12'h7b2, 32'h00000000);
    csr_read(12'h7b2, rd); check("R10 other addr", rd, 32'h0);
    csr_read(A_CTRL, rd);  check("R10 other addr no write", rd, 32'h4000BE07);

    // Sweep: events x privilege x ebreak enables x step bit
    exp_cause = 3'd0;
    exp_dpc   = 32'h12345678;
    idx = 0;
    for (int ev = 0; ev < 16; ev++) begin
      for (int pv = 0; pv < 4; pv++) begin
        for (int en = 0; en < 8; en++) begin
          for (int st = 0; st < 2; st++) begin
            logic [1:0]  prv_w;
            logic        stepie, stopcnt, stoptim, eb_ok, s_h, h_h, e_h, t_h, tk;
            logic [2:0]  c;
            logic [31:0] w, pc;
            prv_w   = ~2'(pv);
            stepie  = 1'(ev) ^ 1'(pv);
            stopcnt = 1'(pv >> 1) ^ 1'(en);
            stoptim = 1'(st) ^ 1'(en >> 1);
            w = (32'(en >> 2 & 1) << 15) | (32'(en >> 1 & 1) << 13) |
                (32'(en & 1) << 12) | (32'(stepie) << 11) | (32'(stopcnt) << 10) |
                (32'(stoptim) << 9) | (32'(st) << 2) | 32'(prv_w);
            csr_write(A_CTRL, w);
            if (debug_mode_o) do_resume();
            eb_ok = (pv == 3) ? 1'(en >> 2) : (pv == 1) ? 1'(en >> 1) :
                    (pv == 0) ? 1'(en) : 1'b0;
            s_h = 1'(ev) & 1'(st);
            h_h = 1'(ev >> 1);
            e_h = 1'(ev >> 2) & eb_ok;
            t_h = 1'(ev >> 3);
            tk  = s_h | h_h | e_h | t_h;
            c   = s_h ? 3'd4 : h_h ? 3'd3 : e_h ? 3'd1 : t_h ? 3'd2 : 3'd0;
            pc  = 32'h1000 + 32'(idx) * 4 + 32'(st);
            @(negedge clk);
            step_done_i = 1'(ev); haltreq_i = 1'(ev >> 1);
            ebreak_i = 1'(ev >> 2); trigger_i = 1'(ev >> 3);
            cur_priv_i = 2'(pv); resume_pc_i = pc;
            #1;
            check("R3 R4 enter", enter_o, tk);
            check("R8 stop count on entry", stop_count_o, stopcnt & tk & (c == 3'd1));
            check("R9 irq mask", irq_mask_o, 1'(st) & !stepie);
            @(negedge clk);
            clear_events();
            #1;
            if (tk) begin
              exp_cause = c;
              exp_dpc   = pc & 32'hFFFFFFFE;
            end
            check("R5 mode", debug_mode_o, tk);
            check("R2 cause", cause_o, exp_cause);
            check("R5 saved priv", saved_priv_o, tk ? 2'(pv) : prv_w);
            check("R5 saved pc", dpc_o, exp_dpc);
            check("R8 stop time", stop_time_o, stoptim & tk);
            check("R8 stop count halted", stop_count_o, stopcnt & tk);
            idx++;
          end
        end
      end
    end

    // R6: events ignored in Debug Mode
    csr_write(A_CTRL, 32'h0000B000);
    if (debug_mode_o) do_resume();
    @(negedge clk);
    haltreq_i = 1'b1; cur_priv_i = 2'd1; resume_pc_i = 32'h2220;
    @(negedge clk);
    clear_events();
    #1 check("R6 entered", debug_mode_o, 1'b1);
    @(negedge clk);
    ebreak_i = 1'b1; trigger_i = 1'b1; haltreq_i = 1'b1; step_done_i = 1'b1;
    cur_priv_i = 2'd0; resume_pc_i = 32'hDEAD0;
    #1 check("R6 no enter", enter_o, 1'b0);
    @(negedge clk);
    clear_events();
    #1;
    check("R6 cause kept", cause_o, 3'd3);
    check("R6 priv kept", saved_priv_o, 2'd1);
    check("R6 pc kept", dpc_o, 32'h2220);

    // R7: resume with edited privilege and address
    csr_write(A_CTRL, 32'h00000001);
    csr_write(A_RPC, 32'h00008000);
    do_resume();
    #1;
    check("R7 left mode", debug_mode_o, 1'b0);
    check("R7 restore priv", saved_priv_o, 2'd1);
    check("R7 restore pc", dpc_o, 32'h8000);
    do_resume();
    #1 check("R7 resume ignored", debug_mode_o, 1'b0);
    check("R7 pc after stray resume", dpc_o, 32'h8000);

    // R11: write and entry in the same cycle
    @(negedge clk);
    csr_we_i = 1'b1; csr_addr_i = A_CTRL; csr_wdata_i = 32'h000081C0;
    haltreq_i = 1'b1; cur_priv_i = 2'd3; resume_pc_i = 32'h4445;
    @(negedge clk);
    csr_we_i = 1'b0; clear_events();
    #1 check("R11 mode", debug_mode_o, 1'b1);
    csr_read(A_CTRL, rd); check("R11 ctrl", rd, 32'h400080C3);
    csr_read(A_RPC, rd);  check("R11 pc", rd, 32'h4444);

    finished = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule